// File: doc/BRIEF.md
# XOR Interleave Target Selector

This block picks which downstream target owns a given slot of an interleaved memory window. The window is set up with a base address, a granularity that is a power of two in bytes, a way count and up to four 64-bit-class XOR masks, of which the low 52 address bits are used. Each request gives a position inside the window. The block forms the address of that position. It then builds the target index from two terms. The first is one parity bit per mask: the XOR of all bits of the address ANDed with that mask. The second, used for way counts that are a multiple of three, is a modulo-3 residue. The way count decides which terms apply.

Requests are sampled on a one-cycle start pulse. The result comes out one clock later as a registered index, together with either a valid pulse or a configuration-error pulse. An inconsistent setup never gives a valid target. These are an unsupported way count, a target count that differs from the way count, or too few masks.

Top module: `xor_ilv_sel`

## Requirements
- R1: With a way count of 1 and a matching target count, the result is index 0 with a valid pulse, whatever the masks, mask count, base or position.
- R2: The selection address is (window base + position × 2^gran_lg) truncated to 52 bits.
- R3: For 2, 4, 8 and 16 ways, bit i of the index is the XOR-reduction of (address AND mask i), where mask i occupies bits [52·i+51 : 52·i] of the mask bus; the remaining index bits are 0.
- R4: The number of masks in use is log2(ways) for 2, 4, 8 and 16 ways, log2(ways/3) for 6 and 12 ways, and none for 1 or 3 ways; masks above that count have no effect on the index.
- R5: For 3 ways, the index is ((address with bits below gran_lg cleared) mod 3), a value 0 to 2.
- R6: For 6 and 12 ways, the address with bits below gran_lg + log2(ways/3) cleared is reduced mod 3, shifted left by the mask count in use and ORed with the parity bits.
- R7: When the way count differs from the target count, the result is an error pulse with no valid pulse and index 0.
- R8: When the supplied mask count is below the count needed (R4), the result is an error pulse with no valid pulse and index 0; a 3-way setup with no masks is accepted.
- R9: A way count outside {1,2,3,4,6,8,12,16} gives an error pulse with no valid pulse and index 0.
- R10: Every start pulse produces exactly one result, either valid or error, one clock later; back-to-back starts give back-to-back results; without a start no pulse appears and the index holds its last value.
- R11: While reset is applied and after its release, the index, valid and error outputs are 0 until the first start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Samples all request and setup inputs this cycle |
| pos | input | POS_W (16) | Position within the window, in granules |
| win_base | input | ADDR_W (52) | Window base address |
| gran_lg | input | GL_W (5) | log2 of the granularity in bytes |
| ways | input | WAYS_W (5) | Interleave way count |
| tgt_count | input | WAYS_W (5) | Number of targets configured |
| mask_count | input | MCNT_W (3) | Number of XOR masks supplied |
| xor_masks | input | NMASK·ADDR_W (208) | Mask i in bits [52·i+51 : 52·i] |
| tgt_idx | output | TGT_W (4) | Selected target index |
| tgt_vld | output | 1 | One-cycle pulse: index valid |
| cfg_err | output | 1 | One-cycle pulse: setup inconsistent |

## Verification
The bench builds the block with its default parameters: 52-bit addresses, 16-bit positions and a 16-way maximum, which gives four masks and a 4-bit index. Every way count in the supported set can therefore be exercised, and so can the 12-way case where the residue lands in index bits 3:2 above two parity bits. The 52-bit address width also brings the address wrap past the top of the space and mod-3 reduction of high address bits within reach. Error cases cover way counts outside the set, target mismatches and mask shortfalls at each count.

// File: rtl/xis_pkg.sv
`timescale 1ns/1ps
package xis_pkg;

  typedef enum logic [1:0] {
    SEL_ZERO = 2'd0,
    SEL_PAR  = 2'd1,
    SEL_MOD  = 2'd2,
    SEL_MIX  = 2'd3
  } sel_mode_e;

  typedef struct packed {
    logic      ok;
    sel_mode_e mode;
    logic [2:0] need;    // masks consumed
    logic [1:0] lo_add;  // extra low bits cleared before mod-3
  } ways_dec_t;

  function automatic ways_dec_t decode_ways(input logic [7:0] w);
    ways_dec_t d;
    d = '{ok: 1'b0, mode: SEL_ZERO, need: 3'd0, lo_add: 2'd0};
    case (w)
      8'd1:  d = '{ok: 1'b1, mode: SEL_ZERO, need: 3'd0, lo_add: 2'd0};
      8'd2:  d = '{ok: 1'b1, mode: SEL_PAR,  need: 3'd1, lo_add: 2'd0};
      8'd3:  d = '{ok: 1'b1, mode: SEL_MOD,  need: 3'd0, lo_add: 2'd0};
      8'd4:  d = '{ok: 1'b1, mode: SEL_PAR,  need: 3'd2, lo_add: 2'd0};
      8'd6:  d = '{ok: 1'b1, mode: SEL_MIX,  need: 3'd1, lo_add: 2'd1};
      8'd8:  d = '{ok: 1'b1, mode: SEL_PAR,  need: 3'd3, lo_add: 2'd0};
      8'd12: d = '{ok: 1'b1, mode: SEL_MIX,  need: 3'd2, lo_add: 2'd2};
      8'd16: d = '{ok: 1'b1, mode: SEL_PAR,  need: 3'd4, lo_add: 2'd0};
      default: d = '{ok: 1'b0, mode: SEL_ZERO, need: 3'd0, lo_add: 2'd0};
    endcase
    return d;
  endfunction

  // Residue accumulate: a in 0..2, d is a base-4 digit (4 == 1 mod 3)
  function automatic logic [1:0] add_mod3(input logic [1:0] a, input logic [1:0] d);
    logic [2:0] s;
    s = {1'b0, a} + {1'b0, d};
    if (s >= 3'd3) s = s - 3'd3;
    return s[1:0];
  endfunction

endpackage

// File: rtl/xis_rst_sync.sv
`timescale 1ns/1ps
module xis_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/xis_addr_gen.sv
`timescale 1ns/1ps
module xis_addr_gen #(
  parameter int ADDR_W = 52,
  parameter int POS_W  = 16,
  parameter int GL_W   = 5
) (
  input  logic [ADDR_W-1:0] win_base,
  input  logic [POS_W-1:0]  pos,
  input  logic [GL_W-1:0]   gran_lg,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] pos_ext;
  logic [ADDR_W-1:0] offset;

  assign pos_ext = ADDR_W'(pos);
  assign offset  = pos_ext << gran_lg;
  assign addr    = win_base + offset;
endmodule

// File: rtl/xis_parity.sv
`timescale 1ns/1ps
module xis_parity #(
  parameter int ADDR_W = 52,
  parameter int NMASK  = 4
) (
  input  logic [ADDR_W-1:0]       addr,
  input  logic [NMASK*ADDR_W-1:0] xor_masks,
  output logic [NMASK-1:0]        par
);
  for (genvar g = 0; g < NMASK; g++) begin : g_par
    assign par[g] = ^(addr & xor_masks[g*ADDR_W +: ADDR_W]);
  end
endmodule

// File: rtl/xis_mod3.sv
`timescale 1ns/1ps
module xis_mod3 import xis_pkg::*; #(
  parameter int ADDR_W = 52,
  parameter int LO_W   = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LO_W-1:0]   lo,
  output logic [1:0]        res
);
  localparam int PAIRS = (ADDR_W + 1) / 2;
  localparam int PAD_W = 2 * PAIRS;

  logic [ADDR_W-1:0] kept;
  logic [PAD_W-1:0]  padded;
  logic [1:0]        chain [PAIRS+1];

  always_comb begin
    for (int b = 0; b < ADDR_W; b++) begin
      kept[b] = addr[b] & (b >= int'(lo));
    end
  end

  assign padded   = PAD_W'(kept);
  assign chain[0] = 2'd0;

  for (genvar g = 0; g < PAIRS; g++) begin : g_fold
    assign chain[g+1] = add_mod3(chain[g], padded[2*g +: 2]);
  end

  assign res = chain[PAIRS];
endmodule

// File: rtl/xis_cfg_chk.sv
`timescale 1ns/1ps
module xis_cfg_chk import xis_pkg::*; #(
  parameter int MAX_WAYS = 16,
  parameter int WAYS_W   = 5,
  parameter int MCNT_W   = 3
) (
  input  logic [WAYS_W-1:0] ways,
  input  logic [WAYS_W-1:0] tgt_count,
  input  logic [MCNT_W-1:0] mask_count,
  output logic              cfg_bad,
  output sel_mode_e         mode,
  output logic [2:0]        need,
  output logic [1:0]        lo_add
);
  ways_dec_t dec;
  logic      supported;
  logic      short_masks;
  logic      count_diff;

  always_comb begin
    dec         = decode_ways(8'(ways));
    supported   = dec.ok && (int'(ways) <= MAX_WAYS);
    short_masks = int'(mask_count) < int'(dec.need);
    count_diff  = (ways != tgt_count);
    cfg_bad     = !supported || count_diff || short_masks;
    mode        = supported ? dec.mode   : SEL_ZERO;
    need        = supported ? dec.need   : 3'd0;
    lo_add      = supported ? dec.lo_add : 2'd0;
  end
endmodule

// File: rtl/xor_ilv_sel.sv
`timescale 1ns/1ps
module xor_ilv_sel import xis_pkg::*; #(
  parameter int ADDR_W   = 52,
  parameter int POS_W    = 16,
  parameter int GL_W     = 5,
  parameter int MAX_WAYS = 16,
  localparam int NMASK   = $clog2(MAX_WAYS),
  localparam int TGT_W   = $clog2(MAX_WAYS),
  localparam int WAYS_W  = $clog2(MAX_WAYS + 1),
  localparam int MCNT_W  = $clog2(NMASK + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [POS_W-1:0]        pos,
  input  logic [ADDR_W-1:0]       win_base,
  input  logic [GL_W-1:0]         gran_lg,
  input  logic [WAYS_W-1:0]       ways,
  input  logic [WAYS_W-1:0]       tgt_count,
  input  logic [MCNT_W-1:0]       mask_count,
  input  logic [NMASK*ADDR_W-1:0] xor_masks,
  output logic [TGT_W-1:0]        tgt_idx,
  output logic                    tgt_vld,
  output logic                    cfg_err
);
  localparam int LO_W = GL_W + 1;

  logic              rst_sn;
  logic [ADDR_W-1:0] addr;
  logic [NMASK-1:0]  par;
  logic [1:0]        mod3_res;
  logic              cfg_bad;
  sel_mode_e         mode;
  logic [2:0]        need;
  logic [1:0]        lo_add;
  logic [LO_W-1:0]   lo;
  logic [TGT_W-1:0]  par_term;
  logic [TGT_W-1:0]  mod_term;
  logic [TGT_W-1:0]  idx_d;
  logic              vld_d;
  logic              err_d;
  logic [TGT_W-1:0]  idx_q;
  logic              vld_q;
  logic              err_q;

  xis_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sn)
  );

  xis_addr_gen #(.ADDR_W(ADDR_W), .POS_W(POS_W), .GL_W(GL_W)) u_addr (
    .win_base (win_base),
    .pos      (pos),
    .gran_lg  (gran_lg),
    .addr     (addr)
  );

  xis_parity #(.ADDR_W(ADDR_W), .NMASK(NMASK)) u_par (
    .addr      (addr),
    .xor_masks (xor_masks),
    .par       (par)
  );

  xis_cfg_chk #(.MAX_WAYS(MAX_WAYS), .WAYS_W(WAYS_W), .MCNT_W(MCNT_W)) u_cfg (
    .ways       (ways),
    .tgt_count  (tgt_count),
    .mask_count (mask_count),
    .cfg_bad    (cfg_bad),
    .mode       (mode),
    .need       (need),
    .lo_add     (lo_add)
  );

  assign lo = LO_W'(gran_lg) + LO_W'(lo_add);

  xis_mod3 #(.ADDR_W(ADDR_W), .LO_W(LO_W)) u_mod3 (
    .addr (addr),
    .lo   (lo),
    .res  (mod3_res)
  );

  // Next-state: index assembly
  always_comb begin
    par_term = '0;
    for (int i = 0; i < NMASK; i++) begin
      par_term[i] = par[i] & (i < int'(need));
    end
    mod_term = TGT_W'(mod3_res) << need;
    unique case (mode)
      SEL_ZERO: idx_d = '0;
      SEL_PAR:  idx_d = par_term;
      SEL_MOD:  idx_d = mod_term;
      SEL_MIX:  idx_d = par_term | mod_term;
      default:  idx_d = '0;
    endcase
    if (cfg_bad) idx_d = '0;
    vld_d = start & ~cfg_bad;
    err_d = start &  cfg_bad;
  end

  // Registers: index loads only on start
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      idx_q <= '0;
      vld_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (start) idx_q <= idx_d;
      vld_q <= vld_d;
      err_q <= err_d;
    end
  end

  assign tgt_idx = idx_q;
  assign tgt_vld = vld_q;
  assign cfg_err = err_q;
endmodule

// File: rtl/xis_chk.sv
`timescale 1ns/1ps
module xis_chk #(
  parameter int WAYS_W = 5,
  parameter int TGT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [WAYS_W-1:0] ways,
  input logic [WAYS_W-1:0] tgt_count,
  input logic [TGT_W-1:0]  tgt_idx,
  input logic              tgt_vld,
  input logic              cfg_err
);
  // R10: any result pulse follows a start one cycle earlier
  a_r10_pulse_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_vld || cfg_err) |-> $past(start));

  // R10: each start yields a pulse
  a_r10_start_gives_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (tgt_vld || cfg_err));

  // R7: valid and error never together
  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(tgt_vld && cfg_err));

  // R7: count mismatch is an error
  a_r7_count_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (ways != tgt_count)) |=> (cfg_err && !tgt_vld && tgt_idx == '0));

  // R1: single way always picks target 0
  a_r1_single_way: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ways == WAYS_W'(1) && tgt_count == WAYS_W'(1)) |=> (tgt_vld && tgt_idx == '0));

  // R9: unsupported way counts are rejected
  a_r9_unsupported: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !(int'(ways) inside {1, 2, 3, 4, 6, 8, 12, 16})) |=> (cfg_err && !tgt_vld));

  // R4: a valid index addresses one of the ways
  a_r4_idx_below_ways: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_vld |-> (int'(tgt_idx) < int'($past(ways))));
endmodule

bind xor_ilv_sel xis_chk #(.WAYS_W(WAYS_W), .TGT_W(TGT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sn),
  .start     (start),
  .ways      (ways),
  .tgt_count (tgt_count),
  .tgt_idx   (tgt_idx),
  .tgt_vld   (tgt_vld),
  .cfg_err   (cfg_err)
);

// File: tb/tb_xor_ilv_sel.sv
`timescale 1ns/1ps
module tb_xor_ilv_sel;
  localparam int ADDR_W = 52;
  localparam int POS_W  = 16;
  localparam int GL_W   = 5;
  localparam int NMASK  = 4;

  logic                    clk;
  logic                    rst_n;
  logic                    start;
  logic [POS_W-1:0]        pos;
  logic [ADDR_W-1:0]       win_base;
  logic [GL_W-1:0]         gran_lg;
  logic [4:0]              ways;
  logic [4:0]              tgt_count;
  logic [2:0]              mask_count;
  logic [NMASK*ADDR_W-1:0] xor_masks;
  logic [3:0]              tgt_idx;
  logic                    tgt_vld;
  logic                    cfg_err;

  logic [ADDR_W-1:0] mk [NMASK];

  xor_ilv_sel dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pos(pos), .win_base(win_base),
    .gran_lg(gran_lg), .ways(ways), .tgt_count(tgt_count), .mask_count(mask_count),
    .xor_masks(xor_masks), .tgt_idx(tgt_idx), .tgt_vld(tgt_vld), .cfg_err(cfg_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    logic       err;
    logic [3:0] idx;
    string      tag;
  } exp_t;

  exp_t expq[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  logic mon_en = 1'b0;
  logic done   = 1'b0;
  logic [3:0] last_idx = 4'd0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference model written from the requirements
  function automatic logic [4:0] model(input int w, input int nt, input int nm, input int gl,
                                       input logic [63:0] base, input logic [63:0] p);
    int need;
    bit ok;
    int lo;
    logic [63:0] a;
    logic [63:0] m;
    logic [63:0] r;
    logic [3:0] ix;
    ok = 1;
    case (w)
      1: need = 0;  2: need = 1;  3: need = 0;  4: need = 2;
      6: need = 1;  8: need = 3; 12: need = 2; 16: need = 4;
      default: begin ok = 0; need = 0; end
    endcase
    if (!ok || w != nt || nm < need) return 5'b1_0000;
    a  = (base + (p << gl)) & ((64'd1 << 52) - 64'd1);
    ix = 4'd0;
    for (int i = 0; i < need; i++) ix[i] = ^(a & {12'd0, mk[i]});
    if (w == 3 || w == 6 || w == 12) begin
      lo = gl + ((w == 3) ? 0 : ((w == 6) ? 1 : 2));
      m  = a & ~((64'd1 << lo) - 64'd1);
      r  = (m % 64'd3) << need;
      ix = ix | r[3:0];
    end
    return {1'b0, ix};
  endfunction

  task automatic issue(input string tag, input int w, input int nt, input int nm, input int gl,
                       input logic [63:0] base, input int p);
    logic [4:0] e;
    exp_t it;
    e = model(w, nt, nm, gl, base, 64'(p));
    it.err = e[4]; it.idx = e[3:0]; it.tag = tag;
    expq.push_back(it);
    last_idx = e[3:0];
    ways = 5'(w); tgt_count = 5'(nt); mask_count = 3'(nm); gran_lg = 5'(gl);
    win_base = base[ADDR_W-1:0]; pos = POS_W'(p);
    xor_masks = {mk[3], mk[2], mk[1], mk[0]};
    start = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    start = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (mon_en && (tgt_vld || cfg_err)) begin
      if (expq.size() == 0) begin
        check("R10 unexpected result pulse", 1, 0);
      end else begin
        exp_t e;
        e = expq.pop_front();
        check({e.tag, " err"}, 64'(cfg_err), 64'(e.err));
        check({e.tag, " vld"}, 64'(tgt_vld), 64'(!e.err));
        check({e.tag, " idx"}, 64'(tgt_idx), 64'(e.idx));
      end
    end
  end

  // Watchdog
  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; pos = '0; win_base = '0; gran_lg = '0;
    ways = 5'd1; tgt_count = 5'd1; mask_count = '0;
    for (int i = 0; i < NMASK; i++) mk[i] = '0;
    xor_masks = '0;
    repeat (3) @(negedge clk);
    check("R11 reset idx", 64'(tgt_idx), 0);
    check("R11 reset vld", 64'(tgt_vld), 0);
    check("R11 reset err", 64'(cfg_err), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 post-release idx", 64'(tgt_idx), 0);
    check("R11 post-release vld", 64'(tgt_vld), 0);
    check("R11 post-release err", 64'(cfg_err), 0);
    mon_en = 1'b1;

    // R1: single way, masks present but irrelevant
    mk[0] = 52'h404100; mk[1] = 52'h808200; mk[2] = 52'h1010400; mk[3] = 52'h2020800;
    for (int p = 0; p < 4; p++) issue("R1 one way", 1, 1, 0, 8, 64'h1000, p * 7);
    idle(1);

    // R3 reference setup: 4 ways, 256-byte granules
    for (int p = 0; p < 8; p++) issue("R3 four way", 4, 4, 2, 8, 64'h0, p);
    // R2: base shifts the address into a mask bit
    for (int p = 0; p < 4; p++) issue("R2 base offset", 4, 4, 2, 8, 64'h4000, p);
    for (int p = 0; p < 4; p++) issue("R2 large granule", 4, 4, 4, 12, 64'h400000, p);
    issue("R2 wrap at 52 bits", 4, 4, 2, 8, 64'hF_FFFF_FFFF_FF00, 3);
    idle(2);

    // R3: two and eight ways
    for (int p = 0; p < 4; p++) issue("R3 two way", 2, 2, 1, 9, 64'h0, p);
    for (int p = 0; p < 8; p++) issue("R3 eight way", 8, 8, 3, 8, 64'h10000, p);
    // R4: sixteen ways uses all masks
    for (int p = 0; p < 16; p++) issue("R4 sixteen way", 16, 16, 4, 8, 64'h0, p * 3);
    idle(1);

    // R4: masks beyond the needed count do not matter
    mk[2] = 52'hF_FFFF_FFFF_FFFF; mk[3] = 52'hA_AAAA_AAAA_AAAA;
    for (int p = 0; p < 4; p++) issue("R4 unused masks", 4, 4, 4, 8, 64'h0, p);
    mk[2] = 52'h1010400; mk[3] = 52'h2020800;

    // R5: three ways, residue only
    for (int p = 0; p < 9; p++) issue("R5 three way", 3, 3, 0, 8, 64'h0, p);
    for (int p = 0; p < 3; p++) issue("R5 low bits cleared", 3, 3, 0, 8, 64'h80, p);
    issue("R5 high address", 3, 3, 0, 8, 64'h8_0000_0000_0000, 1);

    // R6: six and twelve ways
    for (int p = 0; p < 12; p++) issue("R6 six way", 6, 6, 1, 9, 64'h0, p);
    for (int p = 0; p < 12; p++) issue("R6 twelve way", 12, 12, 2, 8, 64'h12300, p);
    idle(2);

    // R8: too few masks
    issue("R8 eight way two masks", 8, 8, 2, 8, 64'h0, 1);
    issue("R8 sixteen way three masks", 16, 16, 3, 8, 64'h0, 1);
    issue("R8 six way no mask", 6, 6, 0, 8, 64'h0, 1);
    issue("R8 three way no mask ok", 3, 3, 0, 8, 64'h0, 2);
    // R7: way/target mismatch
    issue("R7 mismatch 4/2", 4, 2, 2, 8, 64'h0, 1);
    issue("R7 mismatch 12/16", 12, 16, 2, 8, 64'h0, 5);
    // R9: unsupported way counts
    issue("R9 five ways", 5, 5, 4, 8, 64'h0, 1);
    issue("R9 zero ways", 0, 0, 4, 8, 64'h0, 1);
    issue("R9 seven ways", 7, 7, 4, 8, 64'h0, 1);
    issue("R9 twenty ways", 20, 20, 4, 8, 64'h0, 1);

    // R10: hold after a valid result with no start
    issue("R10 last valid", 4, 4, 2, 8, 64'h0, 3);
    start = 1'b0;
    @(negedge clk);
    pos = 16'h0;
    ways = 5'd2;
    repeat (3) @(negedge clk);
    check("R10 idx holds", 64'(tgt_idx), 64'(last_idx));
    check("R10 no vld without start", 64'(tgt_vld), 0);
    check("R10 no err without start", 64'(cfg_err), 0);
    check("R10 all results returned", 64'(expq.size()), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule